// File: doc/BRIEF.md
# Bus Status Event Encoder

This block sits on the PHY side of the PHY-to-link interface of a serial bus. It records bus events as they happen and reports each one to the link layer as a status word that lasts one clock cycle. The events are bus reset, arbitration reset gap (odd or even), cycle start (odd or even), subaction gap and interface reset. During a status cycle the 2-bit control bus carries the status code. The 8-bit data bus carries a one-hot word, and each bit position stands for one event. When several events are waiting, they are held and sent one per cycle in a fixed order.

A status cycle can be placed on an idle interface. During packet reception it can be placed only in a cycle where the receive path flags a gap. While the receive path is busy, its control and data values pass through to the buses with one cycle of delay. When the interface is inactive, nothing is sent and the events stay queued.

A bus reset has side effects beyond its status word:
- It cancels all pending transfer requests.
- It forces the asynchronous and isochronous phase flags to even.
- It raises a request for an unsolicited register-0 report on a separate channel.

After the interface-reset status word has been sent, the block pulses a reset for the link interface state in the next cycle.

Top module: `bus_status_encoder`

## Requirements
- R1: A status cycle lasts exactly one clock and drives `statCtl` to 2'b01. Outside status cycles and receive pass-through, `statCtl` is 2'b00 and `statData` is 0.
- R2: In a status word, data bit 0 means bus reset, bit 1 arbitration reset gap odd, bit 2 arbitration reset gap even, bit 3 cycle start odd, bit 4 cycle start even, bit 5 subaction gap and bit 6 interface reset. Bit 7 is always 0.
- R3: Exactly one data bit is set in each status word. Events that arrive in the same cycle are sent in separate cycles in this order: bus reset, interface reset, then bits 1 to 5 in ascending order.
- R4: On an idle, active interface, an event strobed in the cycle before clock edge N appears on the status outputs after edge N+1.
- R5: While `rxBusy` is high, a status word is sent only at an edge where `rxGap` is high; otherwise the event stays pending. At other edges with `rxBusy` high, `rxCtl` and `rxData` appear on the outputs after one edge.
- R6: While `linkActive` is low, no status word is sent. Pending events are kept and are sent once `linkActive` returns high.
- R7: A bus reset strobe causes the following, visible after the edge that captures it: a one-cycle pulse on `cancelReqs`, a one-cycle pulse on `reg0Req`, and both phase flags forced to even (0).
- R8: `linkIfReset` pulses high for one cycle, in the cycle right after the interface-reset status word is on the outputs.
- R9: `asyncFlip` and `isoFlip` each toggle their phase flag at the next edge. A bus reset strobe at the same edge takes priority.
- R10: Synchronous reset clears all pending events, sets both phase flags to even and returns every output to idle.
- R11: Repeated strobes of an event that is already pending merge into a single status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| busEvt | input | 7 | Event strobes, bit positions as in R2 |
| linkActive | input | 1 | Interface active; status is allowed only when high |
| rxBusy | input | 1 | Packet reception in progress; receive path owns the buses |
| rxGap | input | 1 | Receive path gap strobe; a status slot is allowed |
| rxCtl | input | 2 | Control value from the receive path |
| rxData | input | 8 | Data value from the receive path |
| asyncFlip | input | 1 | Toggle the asynchronous phase flag |
| isoFlip | input | 1 | Toggle the isochronous phase flag |
| statCtl | output | 2 | Control bus to the link |
| statData | output | 8 | Data bus to the link |
| asyncPhaseOdd | output | 1 | Asynchronous phase flag, 1 means odd |
| isoPhaseOdd | output | 1 | Isochronous phase flag, 1 means odd |
| cancelReqs | output | 1 | Pulse that cancels pending transfer requests |
| reg0Req | output | 1 | Request for an unsolicited register-0 report |
| linkIfReset | output | 1 | Pulse that resets the link interface state |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 2-bit control bus and status code 2'b01. With these values the reserved top data bit lies outside the event range and can be checked to stay clear. The whole priority sequence of seven events fits in seven consecutive observed cycles. Receive pass-through values are chosen so that they can never be mistaken for a status word.

// File: rtl/bus_status_pkg.sv
package bus_status_pkg;

  localparam int NUM_EV       = 7;
  localparam int EV_BUS_RESET = 0;
  localparam int EV_IF_RESET  = 6;

  typedef struct packed {
    logic              issue;
    logic [NUM_EV-1:0] grant;
  } ctrl_strobes_t;

  function automatic logic [NUM_EV-1:0] pickNext(input logic [NUM_EV-1:0] pend);
    logic [NUM_EV-1:0] sel;
    sel = '0;
    if (pend[EV_BUS_RESET]) begin
      sel[EV_BUS_RESET] = 1'b1;
    end else if (pend[EV_IF_RESET]) begin
      sel[EV_IF_RESET] = 1'b1;
    end else begin
      for (int i = EV_BUS_RESET + 1; i < EV_IF_RESET; i++) begin
        if (pend[i] && (sel == '0)) sel[i] = 1'b1;
      end
    end
    return sel;
  endfunction

endpackage

// File: rtl/bus_status_ctrl.sv
module bus_status_ctrl
  import bus_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] evtIn,
  input  logic              linkActive,
  input  logic              rxBusy,
  input  logic              rxGap,
  input  logic              asyncFlip,
  input  logic              isoFlip,
  output ctrl_strobes_t     strobes,
  output logic              asyncOdd,
  output logic              isoOdd,
  output logic              cancelPulse,
  output logic              reg0Pulse
);

  logic [NUM_EV-1:0] pend;
  logic [NUM_EV-1:0] grantVec;
  logic              slotOpen;
  logic              busResetHit;

  // A status slot exists only on an active interface that is idle or in a receive gap.
  assign slotOpen    = linkActive && (!rxBusy || rxGap);
  assign grantVec    = slotOpen ? pickNext(pend) : '0;
  assign busResetHit = evtIn[EV_BUS_RESET];

  assign strobes.issue = |grantVec;
  assign strobes.grant = grantVec;

  // One sticky flag per event: a new strobe wins over the clear from its own grant.
  for (genvar g = 0; g < NUM_EV; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= 1'b0;
      end else begin
        pend[g] <= (pend[g] & ~grantVec[g]) | evtIn[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asyncOdd <= 1'b0;
      isoOdd   <= 1'b0;
    end else if (busResetHit) begin
      asyncOdd <= 1'b0;
      isoOdd   <= 1'b0;
    end else begin
      asyncOdd <= asyncOdd ^ asyncFlip;
      isoOdd   <= isoOdd ^ isoFlip;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cancelPulse <= 1'b0;
      reg0Pulse   <= 1'b0;
    end else begin
      cancelPulse <= busResetHit;
      reg0Pulse   <= busResetHit;
    end
  end

endmodule

// File: rtl/bus_status_dpath.sv
module bus_status_dpath
  import bus_status_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              CTL_W       = 2,
  parameter logic [CTL_W-1:0] STATUS_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobes_t     strobes,
  input  logic              rxBusy,
  input  logic [CTL_W-1:0]  rxCtl,
  input  logic [DATA_W-1:0] rxData,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ifResetPulse
);

  localparam int EV_BITS = (NUM_EV < DATA_W) ? NUM_EV : DATA_W;

  logic [DATA_W-1:0] statusWord;
  logic              ifRstSent;

  // Event bits map straight onto data positions; the bits above them stay clear.
  for (genvar b = 0; b < DATA_W; b++) begin : g_word
    if (b < EV_BITS) begin : g_ev
      assign statusWord[b] = strobes.grant[b];
    end else begin : g_rsv
      assign statusWord[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlOut  <= '0;
      dataOut <= '0;
    end else if (strobes.issue) begin
      ctlOut  <= STATUS_CODE;
      dataOut <= statusWord;
    end else if (rxBusy) begin
      ctlOut  <= rxCtl;
      dataOut <= rxData;
    end else begin
      ctlOut  <= '0;
      dataOut <= '0;
    end
  end

  // The interface reset follows in the cycle after its status word is on the bus.
  always_ff @(posedge clk) begin
    if (rst) begin
      ifRstSent    <= 1'b0;
      ifResetPulse <= 1'b0;
    end else begin
      ifRstSent    <= strobes.issue && strobes.grant[EV_IF_RESET];
      ifResetPulse <= ifRstSent;
    end
  end

endmodule

// File: rtl/bus_status_encoder.sv
module bus_status_encoder
  import bus_status_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               CTL_W       = 2,
  parameter logic [CTL_W-1:0] STATUS_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] busEvt,
  input  logic              linkActive,
  input  logic              rxBusy,
  input  logic              rxGap,
  input  logic [CTL_W-1:0]  rxCtl,
  input  logic [DATA_W-1:0] rxData,
  input  logic              asyncFlip,
  input  logic              isoFlip,
  output logic [CTL_W-1:0]  statCtl,
  output logic [DATA_W-1:0] statData,
  output logic              asyncPhaseOdd,
  output logic              isoPhaseOdd,
  output logic              cancelReqs,
  output logic              reg0Req,
  output logic              linkIfReset
);

  ctrl_strobes_t ctrlStrb;

  bus_status_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .evtIn       (busEvt),
    .linkActive  (linkActive),
    .rxBusy      (rxBusy),
    .rxGap       (rxGap),
    .asyncFlip   (asyncFlip),
    .isoFlip     (isoFlip),
    .strobes     (ctrlStrb),
    .asyncOdd    (asyncPhaseOdd),
    .isoOdd      (isoPhaseOdd),
    .cancelPulse (cancelReqs),
    .reg0Pulse   (reg0Req)
  );

  bus_status_dpath #(
    .DATA_W      (DATA_W),
    .CTL_W       (CTL_W),
    .STATUS_CODE (STATUS_CODE)
  ) u_dpath (
    .clk          (clk),
    .rst          (rst),
    .strobes      (ctrlStrb),
    .rxBusy       (rxBusy),
    .rxCtl        (rxCtl),
    .rxData       (rxData),
    .ctlOut       (statCtl),
    .dataOut      (statData),
    .ifResetPulse (linkIfReset)
  );

endmodule

// File: rtl/bus_status_checker.sv
module bus_status_checker
  import bus_status_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               CTL_W       = 2,
  parameter logic [CTL_W-1:0] STATUS_CODE = 2'b01
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EV-1:0] busEvt,
  input logic              linkActive,
  input logic              rxBusy,
  input logic              rxGap,
  input logic [CTL_W-1:0]  statCtl,
  input logic [DATA_W-1:0] statData,
  input logic              asyncPhaseOdd,
  input logic              isoPhaseOdd,
  input logic              cancelReqs,
  input logic              reg0Req,
  input logic              linkIfReset,
  input ctrl_strobes_t     ctrlStrb
);

  AST_ISSUE_DRIVES_STATUS: assert property (@(posedge clk) disable iff (rst)
    ctrlStrb.issue |=> (statCtl == STATUS_CODE && $onehot(statData))); // R1

  AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctrlStrb.issue |=> !statData[DATA_W-1]); // R2

  AST_ONE_EVENT_PER_SLOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrlStrb.grant)); // R3

  AST_RX_GAP_ONLY: assert property (@(posedge clk) disable iff (rst)
    (rxBusy && !rxGap) |-> !ctrlStrb.issue); // R5

  AST_INACTIVE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !linkActive |-> !ctrlStrb.issue); // R6

  AST_BUS_RESET_EFFECTS: assert property (@(posedge clk) disable iff (rst)
    busEvt[EV_BUS_RESET] |=> (cancelReqs && reg0Req && !asyncPhaseOdd && !isoPhaseOdd)); // R7

  AST_IF_RESET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (ctrlStrb.issue && ctrlStrb.grant[EV_IF_RESET]) |=> ##1 linkIfReset); // R8

endmodule

bind bus_status_encoder bus_status_checker #(
  .DATA_W      (DATA_W),
  .CTL_W       (CTL_W),
  .STATUS_CODE (STATUS_CODE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busEvt        (busEvt),
  .linkActive    (linkActive),
  .rxBusy        (rxBusy),
  .rxGap         (rxGap),
  .statCtl       (statCtl),
  .statData      (statData),
  .asyncPhaseOdd (asyncPhaseOdd),
  .isoPhaseOdd   (isoPhaseOdd),
  .cancelReqs    (cancelReqs),
  .reg0Req       (reg0Req),
  .linkIfReset   (linkIfReset),
  .ctrlStrb      (ctrlStrb)
);

// File: tb/tb_bus_status_encoder.sv
module tb_bus_status_encoder;
  import bus_status_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_EV-1:0] busEvt = '0;
  logic              linkActive = 1'b1;
  logic              rxBusy = 1'b0;
  logic              rxGap = 1'b0;
  logic [1:0]        rxCtl = 2'b00;
  logic [7:0]        rxData = 8'h00;
  logic              asyncFlip = 1'b0;
  logic              isoFlip = 1'b0;
  logic [1:0]        statCtl;
  logic [7:0]        statData;
  logic              asyncPhaseOdd, isoPhaseOdd, cancelReqs, reg0Req, linkIfReset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_status_encoder dut (
    .clk(clk), .rst(rst), .busEvt(busEvt), .linkActive(linkActive),
    .rxBusy(rxBusy), .rxGap(rxGap), .rxCtl(rxCtl), .rxData(rxData),
    .asyncFlip(asyncFlip), .isoFlip(isoFlip), .statCtl(statCtl), .statData(statData),
    .asyncPhaseOdd(asyncPhaseOdd), .isoPhaseOdd(isoPhaseOdd), .cancelReqs(cancelReqs),
    .reg0Req(reg0Req), .linkIfReset(linkIfReset)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Strobe events before the next edge; returns just after that edge.
  task automatic strobe(input logic [NUM_EV-1:0] ev);
    busEvt = ev;
    step();
    busEvt = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 ctl", statCtl, 0);
    chk("R10 data", statData, 0);
    chk("R10 phases", {asyncPhaseOdd, isoPhaseOdd}, 0);
    chk("R10 pulses", {cancelReqs, reg0Req, linkIfReset}, 0);
  endtask

  task automatic t_single_events();
    for (int i = 0; i < NUM_EV; i++) begin
      strobe(7'(1 << i));
      chk("R4 not yet", statCtl, 0);
      step();
      chk("R1 ctl code", statCtl, 2'b01);
      chk("R2 bit map", statData, 1 << i);
      step();
      chk("R1 one cycle", {statCtl, statData}, 0);
      if (i == EV_IF_RESET) chk("R8 link reset pulse", linkIfReset, 1);
      else chk("R8 no pulse", linkIfReset, 0);
      step();
      chk("R8 pulse ends", linkIfReset, 0);
    end
  endtask

  task automatic t_simultaneous();
    int ord[7] = '{0, 6, 1, 2, 3, 4, 5};
    strobe(7'h7F);
    for (int k = 0; k < NUM_EV; k++) begin
      step();
      chk("R3 order", statData, 1 << ord[k]);
      chk("R3 ctl", statCtl, 2'b01);
    end
    step();
    chk("R3 drained", {statCtl, statData}, 0);
    step(); step();
  endtask

  task automatic t_rx_gap();
    rxBusy = 1'b1; rxCtl = 2'b10; rxData = 8'hA5;
    strobe(7'h08);
    chk("R5 passthrough ctl", statCtl, 2'b10);
    chk("R5 passthrough data", statData, 8'hA5);
    step(); step();
    chk("R5 held without gap", statData, 8'hA5);
    rxGap = 1'b1;
    step();
    rxGap = 1'b0;
    chk("R5 status in gap ctl", statCtl, 2'b01);
    chk("R5 status in gap data", statData, 8'h08);
    step();
    chk("R5 passthrough resumes", statData, 8'hA5);
    rxBusy = 1'b0;
    step();
    chk("R1 idle after rx", {statCtl, statData}, 0);
  endtask

  task automatic t_inactive();
    linkActive = 1'b0;
    strobe(7'h20);
    step(); step();
    chk("R6 silent while inactive", {statCtl, statData}, 0);
    linkActive = 1'b1;
    step();
    chk("R6 sent after reactivation", statData, 8'h20);
    step();
  endtask

  task automatic t_merge();
    linkActive = 1'b0;
    strobe(7'h10); strobe(7'h10); strobe(7'h10);
    linkActive = 1'b1;
    step();
    chk("R11 one word", statData, 8'h10);
    step();
    chk("R11 no repeat", {statCtl, statData}, 0);
    step();
    chk("R11 still idle", {statCtl, statData}, 0);
  endtask

  task automatic t_bus_reset_effects();
    asyncFlip = 1'b1; isoFlip = 1'b1;
    step();
    asyncFlip = 1'b0; isoFlip = 1'b0;
    chk("R9 both toggle odd", {asyncPhaseOdd, isoPhaseOdd}, 2'b11);
    isoFlip = 1'b1;
    step();
    isoFlip = 1'b0;
    chk("R9 iso toggle even", {asyncPhaseOdd, isoPhaseOdd}, 2'b10);
    asyncFlip = 1'b1;
    strobe(7'h01);
    asyncFlip = 1'b0;
    chk("R7 cancel", cancelReqs, 1);
    chk("R7 reg0 request", reg0Req, 1);
    chk("R7 R9 phases even", {asyncPhaseOdd, isoPhaseOdd}, 0);
    step();
    chk("R7 pulses end", {cancelReqs, reg0Req}, 0);
    chk("R7 status word", statData, 8'h01);
    step();
  endtask

  task automatic t_reset_clears();
    linkActive = 1'b0;
    strobe(7'h06);
    asyncFlip = 1'b1;
    step();
    asyncFlip = 1'b0;
    do_reset();
    linkActive = 1'b1;
    step(); step();
    chk("R10 pending cleared", {statCtl, statData}, 0);
    chk("R10 phase even", asyncPhaseOdd, 0);
  endtask

  initial begin
    t_reset_state();
    t_single_events();
    t_simultaneous();
    t_rx_gap();
    t_inactive();
    t_merge();
    t_bus_reset_effects();
    t_reset_clears();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule